// File: doc/BRIEF.md
# Receive Frame Status Classifier

This block sits beside the receive path of a 10-Gbit Ethernet MAC. It observes frames on a 64-bit packet stream with valid, start, end and empty markers. When a frame closes, it emits one status record: a 40-bit information word and a 7-bit error word. The information word gives the frame and payload byte counts, the tag depth, the destination address class and the control-frame kind. The error word flags runt and over-long frames, length-field mismatches, a CRC failure reported by an upstream checker, and line errors from the PHY.

The record appears combinationally in the cycle that carries the last beat, so the client can attach it to that beat with no extra latency. Only the first three beats of a frame hold header fields. The block therefore captures a few header words and a running byte count, and needs no frame storage. The maximum frame length is a live input, and each VLAN tag raises the limit by four bytes.

Top module: `rx_frame_status`

## Requirements
- R1: `stat_valid` is high in exactly those cycles in which `in_valid` and `in_eop` are both high. The information and error words are meaningful in that cycle. Cycles with `in_valid` low are skipped and do not count as beats.
- R2: The first byte of each beat is on `in_data[63:56]` and the last is on `in_data[7:0]`. Every beat carries 8 bytes, except the final beat, which carries 8 minus `in_empty`. The frame byte count, FCS included, is reported in info bits 31:16.
- R3: Info bits 15:0 give the data byte count: frame length minus header minus 4 FCS bytes, floored at 0. The header is 14 bytes, 18 with one tag, or 22 with two tags.
- R4: A frame with 0x8100 at bytes 12–13 is tagged. It is double tagged if bytes 16–17 also hold 0x8100. Info bit 33 flags a single tag and info bit 32 flags a double tag; they are never both set.
- R5: Exactly one of three info bits is set. Bit 36 means a broadcast destination (bytes 0–5 all 0xFF). Bit 37 means a multicast destination (LSB of byte 0 set, not broadcast). Bit 38 means a unicast destination (LSB of byte 0 clear).
- R6: An untagged frame with type 0x8808 sets info bit 34 (control). If it also has opcode 0x0001 at bytes 14–15, it sets bit 35 (pause). If it has opcode 0x0101 there, it sets bit 39 (priority flow control).
- R7: Error bit 0 is set when the frame is shorter than 64 bytes.
- R8: Error bit 1 is set when the frame length exceeds `max_len` plus 4 bytes per tag.
- R9: Error bit 2 is set when the length/type field (after the tags) is at most 1500 and differs from the data byte count. The exception is a field below the minimum data size (46 minus 4 per tag) whose frame is padded to exactly that size.
- R10: Error bit 3 copies `in_crc_err` from the end beat; its value on other beats is ignored. Error bits 5:4 are always 0.
- R11: Error bit 6 is set if `in_phy_err` was high on any valid beat of the frame, the end beat included.
- R12: After reset `stat_valid` is low. Each start beat clears all per-frame state, so header fields, PHY errors and counts from an earlier frame never leak into a shorter later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 3 | Unused bytes in the last beat |
| in_data | input | 64 | Frame bytes, first byte in the top lane |
| in_phy_err | input | 1 | PHY line error on this beat |
| in_crc_err | input | 1 | CRC failure flag, read on the last beat |
| max_len | input | 16 | Untagged maximum frame length in bytes |
| stat_valid | output | 1 | Status record strobe |
| stat_info | output | 40 | Length and classification word |
| stat_err | output | 7 | Error word |

## Verification
The assertions assume well-formed framing: every frame opens with a start beat, `in_empty` is non-zero only on an end beat, and `max_len` is at least 64 and stays constant within a frame. The stimulus builds every frame from a byte array with explicit start and end markers, fills the unused lanes of the last beat with zeros, and changes `max_len` only between frames. Idle cycles inside frames check that gaps are not counted as beats.

// File: rtl/rx_frame_status.sv
module rx_frame_status #(
  parameter int MIN_FRAME = 64,
  parameter int LEN_FIELD_MAX = 1500,
  parameter int MIN_DATA = 46
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [2:0]  in_empty,
  input  logic [63:0] in_data,
  input  logic        in_phy_err,
  input  logic        in_crc_err,
  input  logic [15:0] max_len,
  output logic        stat_valid,
  output logic [39:0] stat_info,
  output logic [6:0]  stat_err
);
  localparam logic [15:0] TPID_VLAN = 16'h8100;
  localparam logic [15:0] TYPE_CTRL = 16'h8808;
  localparam logic [15:0] OP_PAUSE  = 16'h0001;
  localparam logic [15:0] OP_PFC    = 16'h0101;

  logic [1:0]  beat_q;
  logic [15:0] cnt_q;
  logic [47:0] da_q;
  logic [31:0] w1_q, w2_q;
  logic        phy_q;

  logic [1:0]  beat;
  logic [47:0] da;
  logic [31:0] w1, w2;
  logic        tag1, tag2;
  logic [1:0]  ntag;
  logic [15:0] lt, op, pkt, hdr_fcs, data_len, min_data, tag_add;
  logic [3:0]  nbytes;
  logic [16:0] limit;
  logic        ctrl, bcast, mc_bit, phy, len_err;

  assign beat   = in_sop ? 2'd0 : beat_q;
  assign da     = in_sop ? in_data[63:16] : da_q;
  assign w1     = (beat == 2'd1) ? in_data[31:0] : (beat > 2'd1 ? w1_q : 32'd0);
  assign w2     = (beat == 2'd2) ? {in_data[63:48], in_data[31:16]} :
                  (beat == 2'd3 ? w2_q : 32'd0);

  assign tag1   = (w1[31:16] == TPID_VLAN);
  assign tag2   = tag1 && (w2[31:16] == TPID_VLAN);
  assign ntag   = tag2 ? 2'd2 : (tag1 ? 2'd1 : 2'd0);
  assign lt     = tag2 ? w2[15:0] : (tag1 ? w2[31:16] : w1[31:16]);
  assign op     = w1[15:0];

  assign nbytes = in_eop ? (4'd8 - {1'b0, in_empty}) : 4'd8;
  assign pkt    = (in_sop ? 16'd0 : cnt_q) + {12'd0, nbytes};

  assign tag_add  = {12'd0, ntag, 2'b00};
  assign hdr_fcs  = 16'd18 + tag_add;
  assign data_len = (pkt > hdr_fcs) ? (pkt - hdr_fcs) : 16'd0;
  assign min_data = 16'(MIN_DATA) - tag_add;
  assign limit    = {1'b0, max_len} + {1'b0, tag_add};

  assign len_err = (lt <= 16'(LEN_FIELD_MAX)) && (data_len != lt) &&
                   !((lt < min_data) && (data_len == min_data));

  assign ctrl   = !tag1 && (w1[31:16] == TYPE_CTRL);
  assign bcast  = (da == 48'hFFFF_FFFF_FFFF);
  assign mc_bit = da[40];
  assign phy    = (in_sop ? 1'b0 : phy_q) | in_phy_err;

  assign stat_valid = in_valid && in_eop;
  assign stat_info  = {ctrl && (op == OP_PFC), !mc_bit, mc_bit && !bcast, bcast,
                       ctrl && (op == OP_PAUSE), ctrl, tag1 && !tag2, tag2,
                       pkt, data_len};
  assign stat_err   = {phy, 2'b00, in_crc_err, len_err,
                       ({1'b0, pkt} > limit), (pkt < 16'(MIN_FRAME))};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      cnt_q  <= '0;
      da_q   <= '0;
      w1_q   <= '0;
      w2_q   <= '0;
      phy_q  <= 1'b0;
    end else if (in_valid) begin
      beat_q <= (beat == 2'd3) ? 2'd3 : beat + 2'd1;
      cnt_q  <= pkt;
      phy_q  <= phy;
      if (beat == 2'd0) da_q <= in_data[63:16];
      if (beat == 2'd1) w1_q <= in_data[31:0];
      if (beat == 2'd2) w2_q <= {in_data[63:48], in_data[31:16]};
    end
  end
endmodule

// File: rtl/rx_frame_status_chk.sv
module rx_frame_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_phy_err,
  input logic [15:0] max_len,
  input logic        stat_valid,
  input logic [39:0] stat_info,
  input logic [6:0]  stat_err
);
  AST_STROBE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> in_valid); // R1
  AST_PAYLOAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_info[15:0] <= stat_info[31:16]); // R3
  AST_TAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !(stat_info[33] && stat_info[32])); // R4
  AST_ONE_CAST: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $countones(stat_info[38:36]) == 1); // R5
  AST_KIND_IMPLIES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && (stat_info[35] || stat_info[39]) |-> stat_info[34]); // R6
  AST_SIZE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && (max_len >= 16'd64) |-> !(stat_err[0] && stat_err[1])); // R7 R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_err[5:4] == 2'b00); // R10
  AST_PHY_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && in_phy_err |-> stat_err[6]); // R11
endmodule

bind rx_frame_status rx_frame_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phy_err(in_phy_err),
  .max_len(max_len), .stat_valid(stat_valid), .stat_info(stat_info),
  .stat_err(stat_err)
);

// File: tb/rx_frame_status_tb_top.sv
module rx_frame_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [2:0] in_empty = '0;
  logic [63:0] in_data = '0;
  logic in_phy_err = 1'b0, in_crc_err = 1'b0;
  logic [15:0] max_len = 16'd1518;
  logic stat_valid;
  logic [39:0] stat_info;
  logic [6:0] stat_err;

  int checks = 0, errors = 0;
  logic [39:0] q_info[$];
  logic [6:0]  q_err[$];
  logic [7:0]  fb [0:4095];

  always #5 clk = ~clk;

  rx_frame_status dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_empty(in_empty), .in_data(in_data),
    .in_phy_err(in_phy_err), .in_crc_err(in_crc_err), .max_len(max_len),
    .stat_valid(stat_valid), .stat_info(stat_info), .stat_err(stat_err)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic make_frame(input int n, input int cast, input int tags,
                            input logic [15:0] lt, input logic [15:0] op);
    for (int i = 0; i < n + 16; i++) fb[i] = 8'(i * 13 + 7);
    case (cast)
      1: for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
      2: fb[0] = 8'h01;
      default: fb[0] = 8'h02;
    endcase
    if (tags >= 1) begin fb[12] = 8'h81; fb[13] = 8'h00; end
    if (tags == 2) begin fb[16] = 8'h81; fb[17] = 8'h00; end
    fb[12 + 4 * tags] = lt[15:8];
    fb[13 + 4 * tags] = lt[7:0];
    if (tags == 0 && lt == 16'h8808) begin fb[14] = op[15:8]; fb[15] = op[7:0]; end
    for (int i = n; i < n + 16; i++) fb[i] = 8'h00;
  endtask

  task automatic send(input int n, input int maxl, input int phy_beat,
                      input logic crc, input logic gap);
    int t, p, hf, dl, md, beats;
    logic [15:0] lt, op;
    logic ctrl, bc, mc, phy_any, lerr;
    logic [39:0] ei;
    logic [6:0] ee;
    beats = (n + 7) / 8;
    t = 0;
    if ({fb[12], fb[13]} == 16'h8100) t = ({fb[16], fb[17]} == 16'h8100) ? 2 : 1;
    p = 12 + 4 * t;
    lt = {fb[p], fb[p + 1]};
    op = {fb[14], fb[15]};
    hf = 18 + 4 * t;
    dl = (n > hf) ? n - hf : 0;
    md = 46 - 4 * t;
    ctrl = (t == 0) && (lt == 16'h8808);
    bc = (fb[0] == 8'hFF) && (fb[1] == 8'hFF) && (fb[2] == 8'hFF) &&
         (fb[3] == 8'hFF) && (fb[4] == 8'hFF) && (fb[5] == 8'hFF);
    mc = fb[0][0];
    phy_any = (phy_beat >= 0) && (phy_beat < beats);
    lerr = (lt <= 16'd1500) && (dl != int'(lt)) && !((int'(lt) < md) && (dl == md));
    ei = {ctrl && op == 16'h0101, !mc, mc && !bc, bc, ctrl && op == 16'h0001, ctrl,
          t == 1, t == 2, 16'(n), 16'(dl)};
    ee = {phy_any, 2'b00, crc, lerr, n > maxl + 4 * t, n < 64};
    q_info.push_back(ei);
    q_err.push_back(ee);
    @(posedge clk); #1;
    max_len = 16'(maxl);
    for (int b = 0; b < beats; b++) begin
      if (gap && b == 1) begin
        in_valid = 1'b0; in_eop = 1'b1; in_sop = 1'b1; in_phy_err = 1'b1;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_sop = (b == 0);
      in_eop = (b == beats - 1);
      in_empty = (b == beats - 1) ? 3'(beats * 8 - n) : 3'd0;
      for (int k = 0; k < 8; k++) in_data[63 - 8 * k -: 8] = fb[8 * b + k];
      in_phy_err = (b == phy_beat);
      in_crc_err = (b == beats - 1) ? crc : ~crc;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_empty = '0;
    in_phy_err = 1'b0; in_crc_err = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid || stat_valid)
        chk(32'(stat_valid), 32'(in_valid && in_eop), "R1 strobe");
      if (stat_valid) begin
        if (q_info.size() == 0) chk(32'd1, 32'd0, "R1 unexpected record");
        else begin
          logic [39:0] ei;
          logic [6:0] ee;
          ei = q_info.pop_front();
          ee = q_err.pop_front();
          chk(32'(stat_info[31:16]), 32'(ei[31:16]), "R2 frame length");
          chk(32'(stat_info[15:0]), 32'(ei[15:0]), "R3 data length");
          chk(32'(stat_info[33:32]), 32'(ei[33:32]), "R4 tag bits");
          chk(32'(stat_info[38:36]), 32'(ei[38:36]), "R5 address class");
          chk(32'({stat_info[39], stat_info[35:34]}), 32'({ei[39], ei[35:34]}), "R6 control kind");
          chk(32'(stat_err[0]), 32'(ee[0]), "R7 undersized");
          chk(32'(stat_err[1]), 32'(ee[1]), "R8 oversized");
          chk(32'(stat_err[2]), 32'(ee[2]), "R9 length error");
          chk(32'(stat_err[5:3]), 32'(ee[5:3]), "R10 crc and reserved");
          chk(32'(stat_err[6]), 32'(ee[6]), "R11 phy error");
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(32'(stat_valid), 32'd0, "R12 reset strobe");
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(stat_valid), 32'd0, "R12 idle after reset");

    make_frame(64, 0, 0, 16'h0800, 0);   send(64, 1518, -1, 0, 0);
    make_frame(68, 1, 1, 16'h0800, 0);   send(68, 1518, -1, 0, 1);
    make_frame(1522, 2, 2, 16'h86DD, 0); send(1522, 1518, -1, 0, 1);
    make_frame(1527, 2, 2, 16'h86DD, 0); send(1527, 1518, -1, 0, 0);
    make_frame(8, 0, 0, 16'h0000, 0);    send(8, 1518, -1, 0, 0);     // R12 stale state
    make_frame(64, 2, 0, 16'h8808, 16'h0001); send(64, 1518, -1, 0, 0); // R6 pause
    make_frame(64, 2, 0, 16'h8808, 16'h0101); send(64, 1518, -1, 0, 0); // R6 pfc
    make_frame(64, 0, 0, 16'h8808, 16'h0002); send(64, 1518, -1, 0, 0); // R6 other
    make_frame(118, 0, 0, 16'd100, 0);   send(118, 1518, -1, 0, 0);   // R9 match
    make_frame(130, 0, 0, 16'd100, 0);   send(130, 1518, -1, 0, 0);   // R9 mismatch
    make_frame(64, 0, 0, 16'd10, 0);     send(64, 1518, -1, 0, 0);    // R9 padded
    make_frame(70, 0, 0, 16'd10, 0);     send(70, 1518, -1, 0, 1);    // R9 over-padded
    make_frame(64, 1, 1, 16'd10, 0);     send(64, 1518, -1, 0, 0);    // R9 tagged pad
    make_frame(40, 0, 0, 16'h0800, 0);   send(40, 1518, -1, 0, 0);    // R7 runt
    make_frame(63, 0, 0, 16'h0800, 0);   send(63, 1518, -1, 0, 0);    // R7 edge
    make_frame(1519, 0, 0, 16'h0800, 0); send(1519, 1518, -1, 0, 0);  // R8 over
    make_frame(1518, 0, 0, 16'h0800, 0); send(1518, 1518, -1, 0, 0);  // R8 edge
    make_frame(1519, 0, 0, 16'h0800, 0); send(1519, 2000, -1, 0, 0);  // R8 raised limit
    make_frame(100, 0, 0, 16'h0800, 0);  send(100, 1518, 3, 0, 1);    // R11 mid beat
    make_frame(100, 0, 0, 16'h0800, 0);  send(100, 1518, -1, 0, 0);   // R11 cleared
    make_frame(100, 0, 0, 16'h0800, 0);  send(100, 1518, 12, 0, 0);   // R11 end beat
    make_frame(100, 2, 0, 16'h0800, 0);  send(100, 1518, -1, 1, 0);   // R10 crc
    for (int n = 65; n <= 72; n++) begin
      make_frame(n, n % 3, n % 3 == 0 ? 1 : 0, 16'h0800, 0);
      send(n, 1518, -1, n[0], n[1]);
    end
    repeat (3) @(negedge clk);
    chk(32'(q_info.size()), 32'd0, "R1 all records seen");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule